// File: doc/BRIEF.md
# Clock Alarm Edge Event Register

This block watches four alarm levels from a redundant reference clock and its PLL: loss of the primary reference, loss of the secondary reference, PLL holdover and PLL unlock. Each level is brought into the local clock domain and followed by a small two-state tracker. For every monitored level, the tracker reports a rising edge and a falling edge as separate one-cycle events. Each event sets its own sticky bit in an 8-bit event register.

A host reads the block through a byte-wide read port with eight byte offsets. One offset returns the live alarm levels. Another returns the event register and clears it in the same access. A third returns the interrupt line number that the block is wired to. The interrupt output is high while any event bit is set. It stays high until a read of the event register clears the pending events.

Each level tracker has two states, `LVL_LOW` and `LVL_HIGH`. The `rise` transition goes from `LVL_LOW` to `LVL_HIGH` when the synchronised level is 1, and emits a rising event. The `fall` transition goes from `LVL_HIGH` to `LVL_LOW` when the level is 0, and emits a falling event. In every other case the tracker holds its state. During reset the tracker loads its state from the synchronised level.

The read port decodes the offset into one of four selections:
- `RD_STATUS` (offset 2)
- `RD_EVENT` (offset 6)
- `RD_IDENT` (offset 7)
- `RD_NONE` (all other offsets)

Top module: `clkmon_event_reg`

## Requirements
- R1: A 0-to-1 change on a monitored input sets that input's rising event bit, and a 1-to-0 change sets its falling event bit. Each input passes through a two-stage synchroniser, and the bit is set within three clock edges after the change is sampled.
- R2: Event register bit positions are fixed:
  - bit 0: primary loss rise; bit 1: primary loss fall
  - bit 2: secondary loss rise; bit 3: secondary loss fall
  - bit 4: holdover rise; bit 5: holdover fall
  - bit 6: unlock rise; bit 7: unlock fall
- R3: Event bits are sticky. Once set, a bit stays set through later input changes until the event register is read. Both edge bits of one input can be set together.
- R4: A read at offset 6 returns the event register on the clock after the strobe and clears every bit that was set. A second read with no new edge returns 0x00.
- R5: A new edge whose event bit is set in the same cycle as a clearing read stays set. It is not part of the data that read returns.
- R6: A read at offset 2 returns the live synchronised levels:
  - bit 7: primary loss
  - bit 6: secondary loss
  - bit 5: holdover
  - bit 4: unlock
  - bits 3..0: always 0

  This read does not clear any events.
- R7: A read at offset 7 returns the parameter `IRQ_LINE` in bits 3..0 and zero in bits 7..4. The value 0xF marks the block as absent.
- R8: Reads at offsets 0, 1, 3, 4 and 5 return 0x00 and leave the event register unchanged.
- R9: `irq_o` is high while any event bit is set. It goes low only on the clock where a read at offset 6 clears the register.
- R10: During and after reset the event register is zero and `irq_o` is low. An input held high through reset produces no event.
- R11: `rd_data_o` keeps its value on every clock without a read strobe. It is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_los_i | input | 1 | Primary reference loss level (asynchronous) |
| sec_los_i | input | 1 | Secondary reference loss level (asynchronous) |
| holdover_i | input | 1 | PLL holdover level (asynchronous) |
| unlock_i | input | 1 | PLL unlock level (asynchronous) |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| rd_addr_i | input | 3 | Byte offset of the read |
| rd_data_o | output | 8 | Read data, valid on the clock after the strobe |
| irq_o | output | 1 | Level interrupt, high while any event is pending |

## Verification
The assertions check these properties on every cycle:
- the returned event byte equals the register contents at the strobe;
- event bits stay set unless a clearing read occurs;
- the interrupt falls only after a read at offset 6;
- the fixed bytes at offsets 2 (low nibble), 7 and the unused offsets hold their values;
- read data holds between strobes.

Only the bench's scenarios can show the following:
- that each edge reaches its correct bit position through the synchroniser latency;
- that a level held high through reset yields no event;
- that an edge landing on the same cycle as a clearing read survives into the next read;
- that status reads leave pending events intact.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
    localparam int unsigned MON_COUNT = 4;
    localparam int unsigned EVT_W     = 2 * MON_COUNT;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned LVL_LSB   = DATA_W - MON_COUNT;

    // Monitored input order; event bits are 2*i (rise) and 2*i+1 (fall)
    localparam int unsigned MON_PRI    = 0;
    localparam int unsigned MON_SEC    = 1;
    localparam int unsigned MON_HOLD   = 2;
    localparam int unsigned MON_UNLOCK = 3;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_IDENT  = 3'd7;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_STATUS,
        RD_EVENT,
        RD_IDENT
    } rd_sel_e;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // No reset: the chain keeps sampling during reset so that the
    // trackers can load a settled level.
    always_ff @(posedge clk) begin
        stage_q[0] <= d_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/clkmon_edge_fsm.sv
module clkmon_edge_fsm
    import clkmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    lvl_state_e state_q, state_nx;

    // State register; reset adopts the current level, so no false edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= lvl_i ? LVL_HIGH : LVL_LOW;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl_i)  state_nx = LVL_HIGH;
            LVL_HIGH: if (!lvl_i) state_nx = LVL_LOW;
            default:  state_nx = LVL_LOW;
        endcase
    end

    // Outputs: one-cycle pulse on each transition
    always_comb begin
        rise_o = 1'b0;
        fall_o = 1'b0;
        unique case (state_q)
            LVL_LOW:  rise_o = lvl_i;
            LVL_HIGH: fall_o = !lvl_i;
            default:  ;
        endcase
    end
endmodule

// File: rtl/clkmon_evt_bank.sv
module clkmon_evt_bank #(
    parameter int unsigned EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] set_i,
    input  logic             clr_i,
    output logic [EVT_W-1:0] evt_o
);
    // One sticky flop per event; a set beats a simultaneous clear
    for (genvar gb = 0; gb < EVT_W; gb++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= set_i[gb] | (bit_q & !clr_i);
            end
        end
        assign evt_o[gb] = bit_q;
    end
endmodule

// File: rtl/clkmon_rd_port.sv
module clkmon_rd_port
    import clkmon_pkg::*;
#(
    parameter logic [3:0] IRQ_LINE = 4'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DATA_W-1:0] status_i,
    input  logic [EVT_W-1:0]  evt_i,
    output logic              clr_evt_o,
    output logic [DATA_W-1:0] rd_data_o
);
    rd_sel_e           sel;
    logic [DATA_W-1:0] mux_d;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        unique case (rd_addr_i)
            OFS_STATUS: sel = RD_STATUS;
            OFS_EVENT:  sel = RD_EVENT;
            OFS_IDENT:  sel = RD_IDENT;
            default:    sel = RD_NONE;
        endcase
    end

    always_comb begin
        unique case (sel)
            RD_STATUS: mux_d = status_i;
            RD_EVENT:  mux_d = evt_i;
            RD_IDENT:  mux_d = {4'h0, IRQ_LINE};
            default:   mux_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_en_i) begin
            data_q <= mux_d;
        end
    end

    assign clr_evt_o = rd_en_i && (sel == RD_EVENT);
    assign rd_data_o = data_q;
endmodule

// File: rtl/clkmon_event_reg.sv
module clkmon_event_reg
    import clkmon_pkg::*;
#(
    parameter logic [3:0]  IRQ_LINE    = 4'd5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_los_i,
    input  logic              sec_los_i,
    input  logic              holdover_i,
    input  logic              unlock_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic [MON_COUNT-1:0] raw_w;
    logic [MON_COUNT-1:0] lvl_w;
    logic [MON_COUNT-1:0] rise_w;
    logic [MON_COUNT-1:0] fall_w;
    logic [EVT_W-1:0]     set_w;
    logic [EVT_W-1:0]     evt_q;
    logic [DATA_W-1:0]    status_w;
    logic                 clr_w;

    assign raw_w[MON_PRI]    = pri_los_i;
    assign raw_w[MON_SEC]    = sec_los_i;
    assign raw_w[MON_HOLD]   = holdover_i;
    assign raw_w[MON_UNLOCK] = unlock_i;

    clkmon_sync #(.WIDTH(MON_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d_i (raw_w),
        .q_o (lvl_w)
    );

    for (genvar gi = 0; gi < MON_COUNT; gi++) begin : g_mon
        clkmon_edge_fsm u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (lvl_w[gi]),
            .rise_o (rise_w[gi]),
            .fall_o (fall_w[gi])
        );
        assign set_w[2*gi]               = rise_w[gi];
        assign set_w[2*gi+1]             = fall_w[gi];
        assign status_w[DATA_W-1-gi]     = lvl_w[gi];
    end
    assign status_w[LVL_LSB-1:0] = '0;

    clkmon_evt_bank #(.EVT_W(EVT_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_w),
        .clr_i (clr_w),
        .evt_o (evt_q)
    );

    clkmon_rd_port #(.IRQ_LINE(IRQ_LINE)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .status_i  (status_w),
        .evt_i     (evt_q),
        .clr_evt_o (clr_w),
        .rd_data_o (rd_data_o)
    );

    assign irq_o = |evt_q;
endmodule

// File: rtl/clkmon_event_reg_chk.sv
module clkmon_event_reg_chk
    import clkmon_pkg::*;
#(
    parameter logic [3:0] IRQ_LINE = 4'd5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              irq_o,
    input logic [EVT_W-1:0]  evt_q
);
    logic evt_rd;
    logic other_rd;
    assign evt_rd   = rd_en_i && (rd_addr_i == OFS_EVENT);
    assign other_rd = rd_en_i && (rd_addr_i != OFS_EVENT)
                      && (rd_addr_i != OFS_STATUS) && (rd_addr_i != OFS_IDENT);

    // R4
    evt_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> rd_data_o == $past(evt_q));

    // R3
    evt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_rd |=> (evt_q & $past(evt_q)) == $past(evt_q));

    // R9
    irq_fall_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(evt_rd));

    // R6
    status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == OFS_STATUS) |=> rd_data_o[3:0] == 4'h0);

    // R7
    ident_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_addr_i == OFS_IDENT) |=> rd_data_o == {4'h0, IRQ_LINE});

    // R8
    unused_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        other_rd |=> rd_data_o == 8'h00);

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));
endmodule

bind clkmon_event_reg clkmon_event_reg_chk #(.IRQ_LINE(IRQ_LINE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .evt_q     (evt_q)
);

// File: tb/clkmon_event_reg_test.sv
module clkmon_event_reg_test;
    localparam logic [3:0] TB_IRQ = 4'h9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pri = 1'b1, sec = 1'b0, hold = 1'b0, unl = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       irq;

    int unsigned n_run = 0;
    int unsigned n_fail = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;

    always #10 clk = ~clk;

    clkmon_event_reg #(.IRQ_LINE(TB_IRQ)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pri_los_i  (pri),
        .sec_los_i  (sec),
        .holdover_i (hold),
        .unlock_i   (unl),
        .rd_en_i    (rd_en),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .irq_o      (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Driver: issue a one-cycle read and queue the expected byte
    task automatic do_read(input logic [2:0] addr, input logic [7:0] exp, input string req);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = addr;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    always @(posedge clk) rd_seen <= rd_en;

    // Monitor: compare each returned byte against the queue
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                n_run++;
                n_fail++;
                $display("FAIL scoreboard: actual 0x%02h expected none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R10: primary loss held high through reset
        repeat (5) @(negedge clk);
        check("R10 irq in reset", {7'd0, irq}, 8'h00);
        check("R11 rd_data after reset", rd_data, 8'h00);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R10 irq after reset", {7'd0, irq}, 8'h00);
        do_read(3'd6, 8'h00, "R10 no false edge");
        do_read(3'd2, 8'h80, "R6 status pri only");
        do_read(3'd7, {4'h0, TB_IRQ}, "R7 ident");
        for (int a = 0; a < 8; a++) begin
            if (a != 2 && a != 6 && a != 7) do_read(a[2:0], 8'h00, "R8 unused offset");
        end

        // R1: secondary rise
        sec = 1'b1;
        settle();
        check("R9 irq pending", {7'd0, irq}, 8'h01);
        do_read(3'd2, 8'hC0, "R6 status pri+sec");
        check("R6 status read keeps irq", {7'd0, irq}, 8'h01);
        do_read(3'd6, 8'h04, "R1 sec rise bit2");
        check("R9 irq cleared", {7'd0, irq}, 8'h00);
        do_read(3'd6, 8'h00, "R4 second read empty");

        // R3: holdover both edges plus unlock rise accumulate
        hold = 1'b1; settle();
        hold = 1'b0; settle();
        unl = 1'b1;  settle();
        do_read(3'd3, 8'h00, "R8 unused read");
        do_read(3'd6, 8'h70, "R3 sticky hold both edges + unlock");

        // R2: three falls at once
        pri = 1'b0; sec = 1'b0; unl = 1'b0;
        settle();
        do_read(3'd6, 8'h8A, "R2 pri/sec/unlock fall bits");
        do_read(3'd2, 8'h00, "R6 status all low");

        // R11: hold between strobes
        hold = 1'b1; settle();
        do_read(3'd6, 8'h10, "R2 hold rise bit4");
        repeat (5) @(negedge clk);
        check("R11 rd_data held", rd_data, 8'h10);
        hold = 1'b0; settle();
        do_read(3'd6, 8'h20, "R2 hold fall bit5");

        // R5: edge coinciding with clearing read
        pri = 1'b1; settle();
        @(negedge clk);
        unl = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = 3'd6;
        exp_q.push_back(8'h01);
        tag_q.push_back("R5 read excludes new edge");
        @(negedge clk);
        rd_en = 1'b0;
        check("R5 irq stays high", {7'd0, irq}, 8'h01);
        do_read(3'd6, 8'h40, "R5 new edge retained");
        do_read(3'd2, 8'h90, "R6 status pri+unlock");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_run++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule